// File: doc/BRIEF.md
# Ordered-Frame Input Scheduler for a Load-Balanced Switch

This block sits on the input side of a two-stage load-balanced switch. Arriving cells carry the index of their destination output flow. Each cell is written into one of N per-flow queues. On every slot strobe the block releases at most one cell towards the first-stage fabric. With that cell it gives the middle port that the cell must take. Each middle port receives an equal share of every flow, and cells of one flow reach consecutive middle ports. This lets the output side restore cell order with bounded buffering.

Slots are grouped into frames of N strobes. At the first slot of a frame the block chooses one flow for the whole frame. A flow that holds at least N cells (a complete frame) always wins over flows that hold fewer. Ties among complete flows are settled by one rotating pointer. When no flow is complete, a second, independent rotating pointer picks a non-empty flow. That flow sends the cells it held when the frame began, and the remaining slots of the frame stay empty. Every flow keeps its own middle-port pointer and its own sequence counter, which wraps at 2N.

Top module: `foff_input_sched`

## Requirements
- R1: After reset, out_valid is low. Every flow's next middle port is 0 and its next sequence number is 0. Both rotating pointers start at flow 0, and the frame position is at its first slot.
- R2: out_valid is high for exactly one cycle, in the cycle after a slot strobe that released a cell, and never without a preceding strobe. At most one cell leaves per strobe.
- R3: A frame is N consecutive slot strobes. The flow is chosen only at the first strobe of a frame, and every cell released in that frame belongs to that flow.
- R4: If any flow holds N or more cells at the first strobe of a frame, a complete flow is chosen, and it releases exactly N cells, one on each strobe of the frame.
- R5: Among complete flows, the choice is the first one found searching upward (mod N) from the complete-frame pointer. That pointer then moves to the chosen flow plus one.
- R6: With no complete flow, the first non-empty flow found searching upward from the partial-frame pointer is chosen. It releases the cells it held at that strobe, the later strobes of the frame release nothing, and the partial pointer moves to the chosen flow plus one. The two pointers never affect each other.
- R7: out_mid of a flow's cell is that flow's previous out_mid plus one, mod N. A flow's first cell after reset goes to middle port 0.
- R8: out_seq of a flow's cell is that flow's previous out_seq plus one, mod 2N. A flow's first cell after reset carries 0.
- R9: Cells of one flow leave with the data they arrived with, in arrival order.
- R10: An arrival to a flow whose queue already holds DEPTH cells is discarded and is never released.
- R11: Occupancy seen by a slot decision and by the full test on arrival is the value before that cycle's arrival and release. A cell arriving in the same cycle as a frame's first strobe is not counted in that decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A cell arrives this cycle |
| in_flow | input | $clog2(N) | Destination flow of the arriving cell |
| in_data | input | DATA_W | Payload of the arriving cell |
| slot | input | 1 | Slot strobe: one cell may leave |
| out_valid | output | 1 | A cell is being released |
| out_flow | output | $clog2(N) | Flow of the released cell |
| out_mid | output | $clog2(N) | Middle port assigned to the cell |
| out_seq | output | $clog2(2N) | Per-flow sequence number, wraps at 2N |
| out_data | output | DATA_W | Payload of the released cell |

## Verification
A wrong per-flow middle-port or sequence pointer is visible on the very next cell of that flow, as an out_mid or out_seq one step off from its predecessor. Pointer damage is therefore caught within one cell of that flow. A stale or misplaced rotating pointer shows up at the next frame start: out_flow names a different flow than the search order predicts. A wrong frame position appears as a frame cut short or split across flows within N strobes. A miscounted queue shows up when a full flow is passed over for a partial one, when an arriving cell is lost or duplicated, or as a partial frame releasing the wrong number of cells. A per-cycle reference model catches each of these in the cycle it happens.

// File: rtl/foff_pkg.sv
package foff_pkg;

    // Kind of frame currently being served
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_FULL = 2'd1,
        FR_PART = 2'd2
    } frame_kind_e;

endpackage

// File: rtl/foff_flow_q.sv
module foff_flow_q #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CW-1:0]     count
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t st_q, st_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              accept;

    function automatic logic [AW-1:0] ring_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        accept = push && (st_q.cnt < CW'(DEPTH));
        if (accept) st_d.wr = ring_inc(st_q.wr);
        if (pop)    st_d.rd = ring_inc(st_q.rd);
        case ({accept, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[st_q.wr] <= push_data;
    end

    assign head_data = mem[st_q.rd];
    assign count     = st_q.cnt;

endmodule

// File: rtl/foff_rr_pick.sv
module foff_rr_pick #(
    parameter int N     = 4,
    localparam int FW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [FW-1:0] base,
    output logic          found,
    output logic [FW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(base) + k;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found = 1'b1;
                idx   = FW'(c);
            end
        end
    end

endmodule

// File: rtl/foff_input_sched.sv
module foff_input_sched
    import foff_pkg::*;
#(
    parameter int N      = 4,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int FW    = $clog2(N),
    localparam int SW    = $clog2(2 * N),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int RW    = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FW-1:0]     in_flow,
    input  logic [DATA_W-1:0] in_data,
    input  logic              slot,
    output logic              out_valid,
    output logic [FW-1:0]     out_flow,
    output logic [FW-1:0]     out_mid,
    output logic [SW-1:0]     out_seq,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        frame_kind_e               kind;
        logic [FW-1:0]             phase;
        logic [FW-1:0]             cur;
        logic [RW-1:0]             remain;
        logic [FW-1:0]             full_rr;
        logic [FW-1:0]             part_rr;
        logic [N-1:0][FW-1:0]      mid;
        logic [N-1:0][SW-1:0]      seq;
        logic                      o_valid;
        logic [FW-1:0]             o_flow;
        logic [FW-1:0]             o_mid;
        logic [SW-1:0]             o_seq;
        logic [DATA_W-1:0]         o_data;
    } sched_t;

    sched_t st_q, st_d;

    logic [N-1:0]      push_vec;
    logic [N-1:0]      pop_vec;
    logic [N-1:0]      full_vec;
    logic [N-1:0]      busy_vec;
    logic [CW-1:0]     count_arr [N];
    logic [DATA_W-1:0] head_arr  [N];
    logic              full_found, part_found;
    logic [FW-1:0]     full_idx, part_idx;

    function automatic logic [FW-1:0] port_inc(input logic [FW-1:0] v);
        return (v == FW'(N - 1)) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [SW-1:0] seq_inc(input logic [SW-1:0] v);
        return (v == SW'(2 * N - 1)) ? '0 : v + 1'b1;
    endfunction

    // Per-flow queues and their occupancy flags
    for (genvar g = 0; g < N; g++) begin : g_flow
        assign push_vec[g] = in_valid && (in_flow == FW'(g));
        assign full_vec[g] = count_arr[g] >= CW'(N);
        assign busy_vec[g] = count_arr[g] != '0;

        foff_flow_q #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W)
        ) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_vec[g]),
            .push_data (in_data),
            .pop       (pop_vec[g]),
            .head_data (head_arr[g]),
            .count     (count_arr[g])
        );
    end

    // Complete-frame search and partial-frame search, separate pointers
    foff_rr_pick #(.N(N)) u_full_pick (
        .req   (full_vec),
        .base  (st_q.full_rr),
        .found (full_found),
        .idx   (full_idx)
    );

    foff_rr_pick #(.N(N)) u_part_pick (
        .req   (busy_vec),
        .base  (st_q.part_rr),
        .found (part_found),
        .idx   (part_idx)
    );

    always_comb begin
        logic [FW-1:0] sel;
        logic [RW-1:0] rem;

        st_d         = st_q;
        st_d.o_valid = 1'b0;
        pop_vec      = '0;
        sel          = st_q.cur;
        rem          = st_q.remain;

        if (slot) begin
            if (st_q.phase == '0) begin
                if (full_found) begin
                    st_d.kind    = FR_FULL;
                    sel          = full_idx;
                    rem          = RW'(N);
                    st_d.full_rr = port_inc(full_idx);
                end else if (part_found) begin
                    st_d.kind    = FR_PART;
                    sel          = part_idx;
                    rem          = RW'(count_arr[part_idx]);
                    st_d.part_rr = port_inc(part_idx);
                end else begin
                    st_d.kind    = FR_IDLE;
                    rem          = '0;
                end
                st_d.cur = sel;
            end

            if (rem != '0) begin
                pop_vec[sel]   = 1'b1;
                st_d.o_valid   = 1'b1;
                st_d.o_flow    = sel;
                st_d.o_mid     = st_q.mid[sel];
                st_d.o_seq     = st_q.seq[sel];
                st_d.o_data    = head_arr[sel];
                st_d.mid[sel]  = port_inc(st_q.mid[sel]);
                st_d.seq[sel]  = seq_inc(st_q.seq[sel]);
                rem            = rem - 1'b1;
            end

            st_d.remain = rem;
            st_d.phase  = port_inc(st_q.phase);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= FR_IDLE;
        end else begin
            st_q      <= st_d;
        end
    end

    assign out_valid = st_q.o_valid;
    assign out_flow  = st_q.o_flow;
    assign out_mid   = st_q.o_mid;
    assign out_seq   = st_q.o_seq;
    assign out_data  = st_q.o_data;

endmodule

// File: rtl/foff_sched_chk.sv
module foff_sched_chk
    import foff_pkg::*;
#(
    parameter int N    = 4,
    localparam int FW  = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot,
    input logic          out_valid,
    input logic [FW-1:0] out_flow,
    input logic [FW-1:0] out_mid,
    input logic [FW-1:0] phase_q,
    input frame_kind_e   kind_q,
    input logic [N-1:0]  full_vec,
    input logic [N-1:0]  pop_vec
);

    logic [N-1:0]          seen_q;
    logic [N-1:0][FW-1:0]  last_mid_q;
    logic [FW-1:0]         want_mid;

    always_comb begin
        want_mid = (last_mid_q[out_flow] == FW'(N - 1)) ? '0 : last_mid_q[out_flow] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= '0;
            last_mid_q <= '0;
        end else if (out_valid) begin
            seen_q[out_flow]     <= 1'b1;
            last_mid_q[out_flow] <= out_mid;
        end
    end

    // R2
    out_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(slot));

    // R2
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));

    // R4
    full_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && phase_q == '0 && |full_vec) |=> kind_q == FR_FULL);

    // R4
    full_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && kind_q == FR_FULL && phase_q != '0) |=> out_valid);

    // R7
    mid_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q[out_flow]) |-> out_mid == want_mid);

    // R7
    mid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seen_q[out_flow]) |-> out_mid == '0);

endmodule

bind foff_input_sched foff_sched_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot),
    .out_valid (out_valid),
    .out_flow  (out_flow),
    .out_mid   (out_mid),
    .phase_q   (st_q.phase),
    .kind_q    (st_q.kind),
    .full_vec  (full_vec),
    .pop_vec   (pop_vec)
);

// File: tb/foff_input_sched_tb.sv
module foff_input_sched_tb;

    localparam int N      = 4;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;
    localparam int FW     = $clog2(N);
    localparam int SW     = $clog2(2 * N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [FW-1:0]     in_flow = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              slot = 1'b0;
    logic              out_valid;
    logic [FW-1:0]     out_flow;
    logic [FW-1:0]     out_mid;
    logic [SW-1:0]     out_seq;
    logic [DATA_W-1:0] out_data;

    always #2 clk = ~clk;

    foff_input_sched #(.N(N), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_flow   (in_flow),
        .in_data   (in_data),
        .slot      (slot),
        .out_valid (out_valid),
        .out_flow  (out_flow),
        .out_mid   (out_mid),
        .out_seq   (out_seq),
        .out_data  (out_data)
    );

    int checks = 0;
    int fails  = 0;

    // ---------------- reference model ----------------
    logic [DATA_W-1:0] mq [N][$];
    int mphase, mcur, mrem, mfull, mpart;
    int mmid [N];
    int mseq [N];
    int exp_valid, exp_flow, exp_mid, exp_seq;
    logic [DATA_W-1:0] exp_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < N; f++) begin
                mq[f].delete();
                mmid[f] = 0;
                mseq[f] = 0;
            end
            mphase = 0; mcur = 0; mrem = 0; mfull = 0; mpart = 0;
            exp_valid = 0; exp_flow = 0; exp_mid = 0; exp_seq = 0; exp_data = '0;
        end else begin
            int pre;
            pre = mq[int'(in_flow)].size();
            exp_valid = 0;
            if (slot) begin
                if (mphase == 0) begin
                    int hit;
                    hit = 0;
                    for (int k = 0; k < N; k++) begin
                        int f;
                        f = (mfull + k) % N;
                        if (!hit && mq[f].size() >= N) begin
                            hit = 1; mcur = f; mrem = N; mfull = (f + 1) % N;
                        end
                    end
                    for (int k = 0; k < N; k++) begin
                        int f;
                        f = (mpart + k) % N;
                        if (!hit && mq[f].size() > 0) begin
                            hit = 1; mcur = f; mrem = mq[f].size(); mpart = (f + 1) % N;
                        end
                    end
                    if (!hit) mrem = 0;
                end
                if (mrem > 0) begin
                    exp_valid = 1;
                    exp_flow  = mcur;
                    exp_mid   = mmid[mcur];
                    exp_seq   = mseq[mcur];
                    exp_data  = mq[mcur].pop_front();
                    mmid[mcur] = (mmid[mcur] + 1) % N;
                    mseq[mcur] = (mseq[mcur] + 1) % (2 * N);
                    mrem--;
                end
                mphase = (mphase + 1) % N;
            end
            if (in_valid && pre < DEPTH) mq[int'(in_flow)].push_back(in_data);
        end
    end

    // ---------------- observation ----------------
    int vcount;
    int flow_mask;
    int first_seq;

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic compare();
        chk(out_valid === 1'(exp_valid), "R2 out_valid", int'(out_valid), exp_valid);
        if (out_valid === 1'b1 && exp_valid == 1) begin
            chk(int'(out_flow) == exp_flow, "R5 out_flow", int'(out_flow), exp_flow);
            chk(int'(out_mid) == exp_mid, "R7 out_mid", int'(out_mid), exp_mid);
            chk(int'(out_seq) == exp_seq, "R8 out_seq", int'(out_seq), exp_seq);
            chk(out_data == exp_data, "R9 out_data", int'(out_data), int'(exp_data));
        end
        if (out_valid === 1'b1) begin
            vcount++;
            flow_mask = flow_mask | (1 << int'(out_flow));
            if (vcount == 1) first_seq = int'(out_seq);
        end
    endtask

    task automatic tick(input logic v, input int f, input int d, input logic s);
        @(negedge clk);
        if (rst_n) compare();
        in_valid = v;
        in_flow  = FW'(f);
        in_data  = DATA_W'(d);
        slot     = s;
    endtask

    task automatic clear_obs();
        vcount = 0; flow_mask = 0; first_seq = -1;
    endtask

    task automatic fill(input int f, input int n, input int base);
        for (int i = 0; i < n; i++) tick(1'b1, f, base + i, 1'b0);
        tick(1'b0, 0, 0, 1'b0);
    endtask

    // run one frame of N strobes and one more cycle to observe its last cell
    task automatic frame();
        clear_obs();
        for (int i = 0; i < N; i++) tick(1'b0, 0, 0, 1'b1);
        tick(1'b0, 0, 0, 1'b0);
        tick(1'b0, 0, 0, 1'b0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        clear_obs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet output after reset
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // Single complete flow: R1 pointers start at zero, R3 one flow per frame
        fill(2, 4, 16'h200);
        frame();
        chk(vcount == N, "R3 cells in frame", vcount, N);
        chk(flow_mask == (1 << 2), "R3 single flow in frame", flow_mask, 1 << 2);
        chk(first_seq == 0, "R1 first seq", first_seq, 0);

        // Complete flow beats older partial flow (R4), then partial (R6)
        fill(1, 2, 16'h110);
        fill(3, 4, 16'h330);
        frame();
        chk(flow_mask == (1 << 3), "R4 full flow chosen", flow_mask, 1 << 3);
        chk(vcount == N, "R4 full frame length", vcount, N);
        frame();
        chk(flow_mask == (1 << 1), "R6 partial flow chosen", flow_mask, 1 << 1);
        chk(vcount == 2, "R6 partial frame length", vcount, 2);

        // Two complete flows: 1 then 2 (full pointer at 0)
        fill(1, 4, 16'h140);
        fill(2, 4, 16'h240);
        frame();
        chk(flow_mask == (1 << 1), "R5 first tie winner", flow_mask, 1 << 1);
        frame();
        chk(flow_mask == (1 << 2), "R5 second tie winner", flow_mask, 1 << 2);
        // Full pointer now at 3: flow 3 wins over flow 0
        fill(0, 4, 16'h050);
        fill(3, 4, 16'h350);
        frame();
        chk(flow_mask == (1 << 3), "R5 search starts at pointer", flow_mask, 1 << 3);
        frame();
        chk(flow_mask == (1 << 0), "R5 pointer wraps", flow_mask, 1 << 0);

        // Partial pointer is at 2, unaffected by full frames (R6)
        fill(0, 1, 16'h060);
        fill(1, 1, 16'h160);
        fill(3, 1, 16'h360);
        frame();
        chk(flow_mask == (1 << 3), "R6 partial pointer order", flow_mask, 1 << 3);
        chk(vcount == 1, "R6 held cells only", vcount, 1);
        frame();
        chk(flow_mask == (1 << 0), "R6 partial pointer wraps", flow_mask, 1 << 0);
        frame();
        chk(flow_mask == (1 << 1), "R6 partial pointer next", flow_mask, 1 << 1);

        // Overflow: 10 arrivals to flow 2, only DEPTH kept (R10); seq wrapped (R8)
        fill(2, 10, 16'h270);
        frame();
        chk(first_seq == 0, "R8 seq wraps at 2N", first_seq, 0);
        begin
            int total;
            total = vcount;
            frame();
            total += vcount;
            frame();
            total += vcount;
            chk(total == DEPTH, "R10 drops beyond depth", total, DEPTH);
        end

        // Arrival in the decision cycle is not counted (R11)
        fill(0, 3, 16'h080);
        clear_obs();
        tick(1'b1, 0, 16'h083, 1'b1);
        for (int i = 1; i < N; i++) tick(1'b0, 0, 0, 1'b1);
        tick(1'b0, 0, 0, 1'b0);
        tick(1'b0, 0, 0, 1'b0);
        chk(vcount == 3, "R11 decision uses old count", vcount, 3);
        frame();
        chk(vcount == 1, "R11 late cell next frame", vcount, 1);

        // Mixed random traffic against the model
        for (int i = 0; i < 4000; i++)
            tick(($urandom % 2) == 0, int'($urandom % N), int'($urandom % 65536),
                 ($urandom % 5) < 3);
        for (int i = 0; i < 80; i++) tick(1'b0, 0, 0, 1'b1);
        tick(1'b0, 0, 0, 1'b0);
        tick(1'b0, 0, 0, 1'b0);
        report();
    end

endmodule